// File: doc/BRIEF.md
# Two-Channel Memory DMA Controller

This block moves data between memory locations without processor help. Software programs each channel through a small memory-mapped register window with a source address, a destination address, a unit count and a control word. It then sets the shared master enable. The engine then copies one unit at a time through a single-beat bus master port. A unit is 1, 2, 4 or 16 bytes. Units run back to back on their own, or each unit waits for the channel's request input.

When a channel's count is used up, its end flag is set and the channel stops. If its interrupt enable is set, an interrupt request is raised. The request carries that channel's 7-bit vector and a shared 4-bit priority level. When both channels are ready at once, the bus goes either to channel 0 first or to the channels in turn, unit by unit.

The register window is 7 bits wide, byte addressed, with 32-bit registers. Channel c occupies `c*0x10`: +0x0 is the source address, +0x4 the destination address, +0x8 the count and +0xC the control word. The vector of channel c is at `0x40 + 4*c`, in bits [6:0]. The operation register is at 0x60: bit 0 is the master enable and bit 1 selects round-robin. The level register is at 0x64, in bits [3:0]. Unmapped addresses read 0. Reads are combinational and writes take effect at the next clock edge.

Top module: `dmac_top`

## Requirements
- R1: After reset every register reads 0, `mem_req` is low and `irq_req` is low.
- R2: The count register keeps only bits [23:0] of a write; bits [31:24] read back as 0 and have no effect on the transfer. Control word bits [8:3] read as 0.
- R3: A channel moves data only while the master enable (operation bit 0), its enable (control bit 0) and a clear end flag (control bit 1) all hold; otherwise it makes no bus access.
- R4: Control bits [11:10] select the unit: 0 gives 1 byte (`mem_size`=0), 1 gives 2 bytes (`mem_size`=1), 2 gives 4 bytes (`mem_size`=2), and 3 gives 16 bytes. A 16-byte unit is four 32-bit read/write pairs at offsets 0, 4, 8 and 12 from the unit's addresses.
- R5: Destination mode bits [15:14] and source mode bits [13:12] step their address after each unit: 01 adds the unit size, 10 subtracts it, and 00 or 11 keep it unchanged.
- R6: In 16-byte mode the source address grows by 16 after every unit, whatever the source mode says.
- R7: The count drops by 1 per unit, or by 4 per 16-byte unit. If fewer than 4 remain in 16-byte mode, the count becomes 0.
- R8: When a running channel's count is 0, its end flag is set and it stops. A channel started with count 0 sets the flag without any bus access.
- R9: Writing 0 to control bit 1 clears the end flag. Writing 1 leaves the flag as it is, so software cannot set it.
- R10: With auto-request (control bit 9) at 0, a unit starts only when the channel's `dreq` bit is high while the engine is idle; with it at 1, units follow each other without a request.
- R11: `irq_req` is high while any channel has both its end flag and interrupt enable (control bit 2) set. `irq_vector` is the vector of the lowest such channel and `irq_level` the level register. The request drops only after a register write.
- R12: With operation bit 1 at 0, channel 0 wins every unit it is ready for. With it at 1, the channel served last loses to any other ready channel.
- R13: A bus access holds `mem_req`, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` steady until `mem_ack`. Data sits right-justified in `mem_rdata` and `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| dreq | input | 2 | Per-channel transfer request |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data, right-justified |
| mem_size | output | 2 | Access width: 0 byte, 1 half-word, 2 word |
| mem_rdata | input | 32 | Bus read data, right-justified |
| mem_ack | input | 1 | Access completed |
| irq_req | output | 1 | Completion interrupt request |
| irq_level | output | 4 | Interrupt priority level |
| irq_vector | output | 7 | Interrupt vector |

## Verification
The bench builds the block with its default parameters: two channels, 32-bit addresses and a 24-bit count. Two channels are enough to show both the fixed and the rotating grant order, and to make both vectors compete for the interrupt outputs. The 24-bit count makes the discarded top byte of a count write visible. The bench memory model spans 4 KiB, which holds forward, reverse, fixed-destination and 16-byte copies in separate regions. This lets every stepping mode be checked against bytes the bench computes itself.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // control word bit positions
    localparam int CTRL_DE = 0;   // channel enable
    localparam int CTRL_TE = 1;   // transfer end flag
    localparam int CTRL_IE = 2;   // interrupt enable
    localparam int CTRL_AR = 9;   // auto-request
    localparam int SZ_LSB  = 10;  // unit size field [11:10]
    localparam int SM_LSB  = 12;  // source mode field [13:12]
    localparam int DM_LSB  = 14;  // destination mode field [15:14]

    localparam logic [1:0] SIZE_BURST = 2'd3;
    localparam logic [1:0] MODE_INC   = 2'b01;
    localparam logic [1:0] MODE_DEC   = 2'b10;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_STEP  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          master_en,
    input  logic          done,
    input  logic          dreq,
    output logic [AW-1:0] sar,
    output logic [AW-1:0] dar,
    output logic [CW-1:0] tcr,
    output logic [15:0]   ctrl,
    output logic          eligible
);

    typedef struct packed {
        logic [AW-1:0] sar;
        logic [AW-1:0] dar;
        logic [CW-1:0] tcr;
        logic [15:0]   ctrl;
    } chan_state_t;

    chan_state_t s_d, s_q;

    logic          running;
    logic [1:0]    dmode, smode, usize;
    logic [AW-1:0] ubytes;
    logic          te_keep;

    always_comb begin
        dmode   = s_q.ctrl[DM_LSB +: 2];
        smode   = s_q.ctrl[SM_LSB +: 2];
        usize   = s_q.ctrl[SZ_LSB +: 2];
        running = master_en && s_q.ctrl[CTRL_DE] && !s_q.ctrl[CTRL_TE];
        case (usize)
            2'd0:    ubytes = AW'(1);
            2'd1:    ubytes = AW'(2);
            2'd2:    ubytes = AW'(4);
            default: ubytes = AW'(16);
        endcase

        s_d     = s_q;
        te_keep = 1'b0;

        if (done) begin
            case (dmode)
                MODE_INC: s_d.dar = s_q.dar + ubytes;
                MODE_DEC: s_d.dar = s_q.dar - ubytes;
                default:  s_d.dar = s_q.dar;
            endcase
            if (usize == SIZE_BURST) begin
                s_d.sar = s_q.sar + AW'(16);
                s_d.tcr = (s_q.tcr < CW'(4)) ? '0 : s_q.tcr - CW'(4);
            end else begin
                case (smode)
                    MODE_INC: s_d.sar = s_q.sar + ubytes;
                    MODE_DEC: s_d.sar = s_q.sar - ubytes;
                    default:  s_d.sar = s_q.sar;
                endcase
                s_d.tcr = s_q.tcr - CW'(1);
            end
        end

        if (running && s_q.tcr == '0) begin
            s_d.ctrl[CTRL_TE] = 1'b1;
        end

        if (wr_en) begin
            case (wr_sel)
                2'd0: s_d.sar = wr_data[AW-1:0];
                2'd1: s_d.dar = wr_data[AW-1:0];
                2'd2: s_d.tcr = wr_data[CW-1:0];
                default: begin
                    te_keep = s_d.ctrl[CTRL_TE] && wr_data[CTRL_TE];
                    s_d.ctrl = {wr_data[15:9], 6'b0, wr_data[CTRL_IE], te_keep, wr_data[CTRL_DE]};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sar      = s_q.sar;
    assign dar      = s_q.dar;
    assign tcr      = s_q.tcr;
    assign ctrl     = s_q.ctrl;
    assign eligible = running && (s_q.tcr != '0) && (s_q.ctrl[CTRL_AR] || dreq);

    // the engine never finishes a unit for a channel whose count is spent
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (s_q.tcr != '0));

    // the end flag only appears after the count stood at zero
    assert_end_on_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ctrl[CTRL_TE]) |-> ($past(s_q.tcr) == '0));

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NUM_CH = 2,
    localparam int IW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] elig,
    input  logic              rr_mode,
    input  logic              take,
    output logic              gnt_valid,
    output logic [IW-1:0]     gnt_idx
);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_state_t;

    arb_state_t s_d, s_q;

    always_comb begin
        gnt_idx = '0;
        if (rr_mode) begin
            for (int k = NUM_CH; k >= 1; k--) begin
                if (elig[(int'(s_q.last) + k) % NUM_CH]) begin
                    gnt_idx = IW'((int'(s_q.last) + k) % NUM_CH);
                end
            end
        end else begin
            for (int j = NUM_CH - 1; j >= 0; j--) begin
                if (elig[j]) gnt_idx = IW'(j);
            end
        end
        gnt_valid = |elig;

        s_d = s_q;
        if (take) s_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.last <= IW'(NUM_CH - 1);
        else        s_q      <= s_d;
    end

    assert_fixed_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rr_mode && elig[0]) |-> (gnt_idx == '0));

    assert_grant_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> elig[gnt_idx]);

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int NUM_CH = 2,
    localparam int IW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_valid,
    input  logic [IW-1:0] gnt_idx,
    input  logic [AW-1:0] sel_sar,
    input  logic [AW-1:0] sel_dar,
    input  logic [1:0]    sel_size,
    output logic          take,
    output logic          done_valid,
    output logic [IW-1:0] done_idx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [1:0]    mem_size,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack
);

    typedef struct packed {
        eng_state_e    st;
        logic [IW-1:0] ch;
        logic [1:0]    size;
        logic [AW-1:0] sar;
        logic [AW-1:0] dar;
        logic [1:0]    beat;
        logic [31:0]   data;
    } eng_t;

    eng_t s_d, s_q;

    logic [AW-1:0] offs;

    always_comb begin
        s_d        = s_q;
        take       = 1'b0;
        done_valid = 1'b0;
        done_idx   = s_q.ch;
        offs       = AW'(s_q.beat) << 2;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = s_q.sar + offs;
        mem_wdata  = s_q.data;
        mem_size   = (s_q.size == SIZE_BURST) ? 2'd2 : s_q.size;

        case (s_q.st)
            ENG_IDLE: begin
                if (gnt_valid) begin
                    take     = 1'b1;
                    s_d.ch   = gnt_idx;
                    s_d.sar  = sel_sar;
                    s_d.dar  = sel_dar;
                    s_d.size = sel_size;
                    s_d.beat = '0;
                    s_d.st   = ENG_READ;
                end
            end
            ENG_READ: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.data = mem_rdata;
                    s_d.st   = ENG_WRITE;
                end
            end
            ENG_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.dar + offs;
                if (mem_ack) begin
                    if (s_q.size == SIZE_BURST && s_q.beat != 2'd3) begin
                        s_d.beat = s_q.beat + 2'd1;
                        s_d.st   = ENG_READ;
                    end else begin
                        s_d.st = ENG_STEP;
                    end
                end
            end
            default: begin
                done_valid = 1'b1;
                s_d.st     = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_bus_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_size)));

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 32,
    parameter int CW     = 24,
    parameter int RA_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RA_W-1:0]   cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [NUM_CH-1:0] dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [1:0]        mem_size,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              irq_req,
    output logic [3:0]        irq_level,
    output logic [6:0]        irq_vector
);

    localparam int IW       = $clog2(NUM_CH);
    localparam int CH_SPAN  = 16;
    localparam int VEC_BASE = 64;
    localparam int OPR_ADDR = 96;
    localparam int LVL_ADDR = 100;

    typedef struct packed {
        logic                  me;
        logic                  rr;
        logic [3:0]            lvl;
        logic [NUM_CH-1:0][6:0] vec;
    } glob_t;

    glob_t st_d, st_q;

    logic [AW-1:0]     ch_sar  [NUM_CH];
    logic [AW-1:0]     ch_dar  [NUM_CH];
    logic [CW-1:0]     ch_tcr  [NUM_CH];
    logic [15:0]       ch_ctrl [NUM_CH];
    logic [NUM_CH-1:0] ch_elig;
    logic [NUM_CH-1:0] ch_wr;

    logic          in_chan;
    logic          gnt_valid, eng_take, done_valid;
    logic [IW-1:0] gnt_idx, done_idx;

    assign in_chan = int'(cfg_addr) < NUM_CH * CH_SPAN;

    // shared registers
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (int'(cfg_addr) == OPR_ADDR) begin
                st_d.me = cfg_wdata[0];
                st_d.rr = cfg_wdata[1];
            end
            if (int'(cfg_addr) == LVL_ADDR) st_d.lvl = cfg_wdata[3:0];
            for (int c = 0; c < NUM_CH; c++) begin
                if (int'(cfg_addr) == VEC_BASE + 4 * c) st_d.vec[c] = cfg_wdata[6:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        cfg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_chan && int'(cfg_addr[RA_W-1:4]) == c) begin
                case (cfg_addr[3:2])
                    2'd0:    cfg_rdata = 32'(ch_sar[c]);
                    2'd1:    cfg_rdata = 32'(ch_dar[c]);
                    2'd2:    cfg_rdata = 32'(ch_tcr[c]);
                    default: cfg_rdata = 32'(ch_ctrl[c]);
                endcase
            end
            if (int'(cfg_addr) == VEC_BASE + 4 * c) cfg_rdata = 32'(st_q.vec[c]);
        end
        if (int'(cfg_addr) == OPR_ADDR) cfg_rdata = {30'b0, st_q.rr, st_q.me};
        if (int'(cfg_addr) == LVL_ADDR) cfg_rdata = {28'b0, st_q.lvl};
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign ch_wr[c] = cfg_we && in_chan && (int'(cfg_addr[RA_W-1:4]) == c);

        dmac_chan #(.AW(AW), .CW(CW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ch_wr[c]),
            .wr_sel    (cfg_addr[3:2]),
            .wr_data   (cfg_wdata),
            .master_en (st_q.me),
            .done      (done_valid && (done_idx == IW'(c))),
            .dreq      (dreq[c]),
            .sar       (ch_sar[c]),
            .dar       (ch_dar[c]),
            .tcr       (ch_tcr[c]),
            .ctrl      (ch_ctrl[c]),
            .eligible  (ch_elig[c])
        );
    end

    dmac_arb #(.NUM_CH(NUM_CH)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (ch_elig),
        .rr_mode   (st_q.rr),
        .take      (eng_take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dmac_engine #(.AW(AW), .NUM_CH(NUM_CH)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_valid  (gnt_valid),
        .gnt_idx    (gnt_idx),
        .sel_sar    (ch_sar[gnt_idx]),
        .sel_dar    (ch_dar[gnt_idx]),
        .sel_size   (ch_ctrl[gnt_idx][SZ_LSB +: 2]),
        .take       (eng_take),
        .done_valid (done_valid),
        .done_idx   (done_idx),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_size   (mem_size),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    // completion interrupt: lowest pending channel supplies the vector
    always_comb begin
        irq_req    = 1'b0;
        irq_vector = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (ch_ctrl[c][CTRL_TE] && ch_ctrl[c][CTRL_IE]) begin
                irq_req    = 1'b1;
                irq_vector = st_q.vec[c];
            end
        end
        irq_level = irq_req ? st_q.lvl : 4'd0;
    end

    assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_take |-> (st_q.me && ch_ctrl[gnt_idx][CTRL_DE] && !ch_ctrl[gnt_idx][CTRL_TE]));

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> $past(cfg_we));

endmodule

// File: tb/test_dmac_top.sv
module test_dmac_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  dreq = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [6:0]  irq_vector;

    always #5 clk = ~clk;

    dmac_top i_dmac_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vector(irq_vector)
    );

    localparam logic [6:0] A_VEC0 = 7'h40;
    localparam logic [6:0] A_VEC1 = 7'h44;
    localparam logic [6:0] A_OPR  = 7'h60;
    localparam logic [6:0] A_LVL  = 7'h64;

    int n_checks = 0;
    int n_fail   = 0;

    // memory model: untouched bytes show a pattern of their address
    logic [7:0]  mem   [4096];
    int          ep    [4096];
    int          epoch = 1;
    int          acc_n = 0;
    logic [31:0] wlog_a [64];
    logic [1:0]  wlog_s [64];
    int          wlog_n = 0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return 8'(a * 7 + (a >> 8) + 32'h11);
    endfunction

    function automatic logic [7:0] rd8(input logic [31:0] a);
        int i = int'(a & 32'hFFF);
        return (ep[i] == epoch) ? mem[i] : pat(a & 32'hFFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            acc_n = acc_n + 1;
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++) begin
                    mem[int'((mem_addr + b) & 32'hFFF)] = mem_wdata[8*b +: 8];
                    ep[int'((mem_addr + b) & 32'hFFF)]  = epoch;
                end
                wlog_a[wlog_n % 64] = mem_addr;
                wlog_s[wlog_n % 64] = mem_size;
                wlog_n = wlog_n + 1;
            end else begin
                logic [31:0] rd;
                rd = '0;
                for (int b = 0; b < (1 << mem_size); b++) rd[8*b +: 8] = rd8(mem_addr + b);
                mem_rdata <= rd;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic setup_chan(input int c, input logic [31:0] src, input logic [31:0] dst,
                              input logic [31:0] cnt, input logic [31:0] ctl);
        cfg_write(7'(c * 16 + 0), src);
        cfg_write(7'(c * 16 + 4), dst);
        cfg_write(7'(c * 16 + 8), cnt);
        cfg_write(7'(c * 16 + 12), ctl);
    endtask

    task automatic wait_te(input int c);
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            cfg_read(7'(c * 16 + 12), d);
            if (d[1]) break;
        end
    endtask

    function automatic int cmp_bytes(input logic [31:0] src, input logic [31:0] dst, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (rd8(dst + i) !== rd8(src + i)) bad++;
        return bad;
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        cfg_read(7'h00, d); chk("R1 ch0 source", d, 0);
        cfg_read(7'h0C, d); chk("R1 ch0 control", d, 0);
        cfg_read(7'h18, d); chk("R1 ch1 count", d, 0);
        cfg_read(A_OPR, d); chk("R1 operation", d, 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 irq_req", 32'(irq_req), 0);
    endtask

    task automatic t_count_width;
        logic [31:0] d;
        cfg_write(7'h08, 32'hFF00_0005);
        cfg_read(7'h08, d); chk("R2 count upper byte dropped", d, 32'h0000_0005);
        cfg_write(7'h0C, 32'hFFFF_FFF8);
        cfg_read(7'h0C, d); chk("R2 control reserved bits", d, 32'h0000_FE00);
        cfg_write(7'h0C, 32'h0);
    endtask

    task automatic t_byte_copy;
        logic [31:0] d;
        int a0;
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(0, 32'h100, 32'h200, 32'hAB00_0005, 32'h5201);
        a0 = acc_n;
        repeat (20) @(negedge clk);
        chk("R3 no access without master enable", 32'(acc_n - a0), 0);
        cfg_write(A_OPR, 1);
        wait_te(0);
        chk("R4 byte copy data", 32'(cmp_bytes(32'h100, 32'h200, 5)), 0);
        chk("R4 byte past end untouched", 32'(rd8(32'h205)), 32'(pat(32'h205)));
        cfg_read(7'h00, d); chk("R5 byte source stepped", d, 32'h105);
        cfg_read(7'h04, d); chk("R5 byte destination stepped", d, 32'h205);
        cfg_read(7'h08, d); chk("R7 byte count at zero", d, 0);
        cfg_read(7'h0C, d); chk("R8 end flag set", d, 32'h5203);
        a0 = acc_n;
        repeat (20) @(negedge clk);
        chk("R8 channel stays stopped", 32'(acc_n - a0), 0);
    endtask

    task automatic t_half_reverse;
        logic [31:0] d;
        int bad = 0;
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(1, 32'h31E, 32'h41E, 4, 32'hA601);
        cfg_write(A_OPR, 1);
        wait_te(1);
        for (int k = 0; k < 4; k++) bad += cmp_bytes(32'h31E - 2 * k, 32'h41E - 2 * k, 2);
        chk("R5 reverse half-word data", 32'(bad), 0);
        cfg_read(7'h10, d); chk("R5 reverse source", d, 32'h316);
        cfg_read(7'h14, d); chk("R5 reverse destination", d, 32'h416);
    endtask

    task automatic t_word_fixed;
        logic [31:0] d;
        int w0;
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(0, 32'h500, 32'h600, 3, 32'hDA01);
        w0 = wlog_n;
        cfg_write(A_OPR, 1);
        wait_te(0);
        chk("R5 fixed destination holds last word", 32'(cmp_bytes(32'h508, 32'h600, 4)), 0);
        chk("R5 fixed destination next byte untouched", 32'(rd8(32'h604)), 32'(pat(32'h604)));
        cfg_read(7'h04, d); chk("R5 mode 11 keeps destination", d, 32'h600);
        cfg_read(7'h00, d); chk("R5 word source stepped", d, 32'h50C);
        chk("R4 word access size", 32'(wlog_s[w0 % 64]), 2);
    endtask

    task automatic t_burst;
        logic [31:0] d;
        int w0;
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(1, 32'h700, 32'h800, 6, 32'h4E01);
        w0 = wlog_n;
        cfg_write(A_OPR, 1);
        wait_te(1);
        chk("R4 burst data", 32'(cmp_bytes(32'h700, 32'h800, 32)), 0);
        chk("R4 burst stops after two units", 32'(rd8(32'h820)), 32'(pat(32'h820)));
        chk("R4 burst write count", 32'(wlog_n - w0), 8);
        for (int b = 0; b < 4; b++)
            chk("R4 burst beat address", wlog_a[(w0 + b) % 64], 32'h800 + 4 * b);
        chk("R4 burst beat size", 32'(wlog_s[(w0 + 1) % 64]), 2);
        cfg_read(7'h10, d); chk("R6 burst source ignores fixed mode", d, 32'h720);
        cfg_read(7'h14, d); chk("R5 burst destination", d, 32'h820);
        cfg_read(7'h18, d); chk("R7 burst count saturates", d, 0);
    endtask

    task automatic t_te_clear;
        logic [31:0] d;
        cfg_write(7'h1C, 32'h4E02);
        cfg_read(7'h1C, d); chk("R9 writing one keeps flag", d, 32'h4E02);
        cfg_write(7'h1C, 32'h4E00);
        cfg_read(7'h1C, d); chk("R9 writing zero clears flag", d, 32'h4E00);
        cfg_write(7'h1C, 32'h4E02);
        cfg_read(7'h1C, d); chk("R9 software cannot set flag", d, 32'h4E00);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        int a0;
        epoch++;
        cfg_write(A_LVL, 9);
        cfg_write(A_VEC0, 32'h45);
        cfg_write(A_VEC1, 32'h2A);
        cfg_write(A_OPR, 0);
        cfg_write(7'h0C, 0);
        setup_chan(1, 32'hB00, 32'hC00, 2, 32'h5205);
        cfg_write(A_OPR, 1);
        wait_te(1);
        @(negedge clk);
        chk("R11 irq raised", 32'(irq_req), 1);
        chk("R11 irq vector ch1", 32'(irq_vector), 32'h2A);
        chk("R11 irq level", 32'(irq_level), 9);
        a0 = acc_n;
        setup_chan(0, 32'hB80, 32'hC80, 0, 32'h0205);
        wait_te(0);
        chk("R8 zero count makes no access", 32'(acc_n - a0), 0);
        @(negedge clk);
        chk("R11 lowest channel vector wins", 32'(irq_vector), 32'h45);
        cfg_write(7'h0C, 0);
        @(negedge clk);
        chk("R11 remaining channel vector", 32'(irq_vector), 32'h2A);
        cfg_write(7'h1C, 0);
        @(negedge clk);
        chk("R11 irq dropped after clears", 32'(irq_req), 0);
    endtask

    task automatic t_dreq;
        logic [31:0] d;
        int a0;
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(0, 32'hD00, 32'hE00, 3, 32'h5001);
        cfg_write(A_OPR, 1);
        a0 = acc_n;
        repeat (20) @(negedge clk);
        chk("R10 no unit without request", 32'(acc_n - a0), 0);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); dreq[0] = 1'b1;
            @(negedge clk); dreq[0] = 1'b0;
            repeat (20) @(negedge clk);
            if (p == 0) begin
                cfg_read(7'h08, d); chk("R10 one unit per request", d, 2);
                chk("R10 one read and one write", 32'(acc_n - a0), 2);
            end
        end
        wait_te(0);
        chk("R10 paced copy data", 32'(cmp_bytes(32'hD00, 32'hE00, 3)), 0);
        cfg_write(7'h0C, 0);
    endtask

    task automatic t_arb(input logic rr);
        int w0;
        logic [31:0] exp_a [4];
        epoch++;
        cfg_write(A_OPR, 0);
        setup_chan(0, 32'h900, 32'hA00, 2, 32'h5201);
        setup_chan(1, 32'h980, 32'hA80, 2, 32'h5201);
        w0 = wlog_n;
        cfg_write(A_OPR, rr ? 3 : 1);
        wait_te(0);
        wait_te(1);
        if (rr) begin
            exp_a[0] = 32'hA00; exp_a[1] = 32'hA80; exp_a[2] = 32'hA01; exp_a[3] = 32'hA81;
        end else begin
            exp_a[0] = 32'hA00; exp_a[1] = 32'hA01; exp_a[2] = 32'hA80; exp_a[3] = 32'hA81;
        end
        for (int i = 0; i < 4; i++)
            chk(rr ? "R12 round-robin order" : "R12 fixed order", wlog_a[(w0 + i) % 64], exp_a[i]);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_width();
        t_byte_copy();
        t_half_reverse();
        t_word_fixed();
        t_burst();
        t_te_clear();
        t_irq();
        t_dreq();
        t_arb(1'b0);
        t_arb(1'b1);
        finish_run();
    end

endmodule